// File: doc/BRIEF.md
# Two-Leg Randomized Route Controller

This block handles the routing decisions of a 2D mesh node that sends every packet through a randomly chosen intermediate node. At injection the source raises a request. The block draws a candidate node index from an internal linear feedback shift register. When the candidate lies inside the mesh, the block accepts the packet and writes the intermediate coordinates, together with a leg flag, into a header register. When the candidate lies outside the mesh, the block rejects it and draws again on the next cycle. This rejection keeps the choice uniform over all nodes even when the node count is not a power of two.

On every hop the same block works out the output port for a header presented to it. While the leg flag is clear, the packet heads for the intermediate node. When the packet reaches that node, the flag is set and the packet carries on toward its final destination without being ejected. Each leg is minimal and travels fully along X before it travels along Y. Under uniform traffic the two legs together average twice the hop count of a direct route, and in return adversarial traffic patterns are spread evenly across the mesh.

Top module: `twoLegRouteCtl`

## Requirements
- R1: While `rst` is high, `injReady` and `stampValid` are 0 and the generator is loaded with `SEED`. The first draw after reset therefore tests the low `IDX_W` bits of `SEED`.
- R2: The candidate is the low `IDX_W` bits of the generator. Node index i stands for x = i mod `MESH_X` and y = i div `MESH_X`. Over a long run every index below `MESH_X*MESH_Y` is drawn, and no other index is ever accepted.
- R3: When `injValid` is high and the candidate is at or above the node count, `injReady` is 0 in that cycle. No header is stamped, and a fresh candidate is tested in the next cycle.
- R4: The generator shifts left once in every cycle in which `injValid` is high, taking in the XOR of the bits selected by `TAPS` (default bits 7, 5, 4 and 3). It holds its value in every cycle in which `injValid` is low, and it is never zero.
- R5: When a candidate is accepted, `injReady` is 1 in the same cycle. In the following cycle `stampValid` is 1 for exactly one cycle, with `stampMidX` and `stampMidY` holding the drawn coordinates.
- R6: `stampPhase` is 1 exactly when the drawn node equals the source node (`nodeX`, `nodeY`) of the accept cycle.
- R7: Port codes are 0 local, 1 east (+X), 2 west (-X), 3 north (+Y) and 4 south (-Y). Toward the current target, the X difference is resolved before the Y difference.
- R8: The target is the intermediate node while the leg flag is 0 and the destination while it is 1. A packet at its intermediate node with the flag at 0 gets `outPhase` 1 and is routed toward the destination in the same decision.
- R9: `outPort` is local only when `outPhase` is 1 and the current node equals the destination. A packet at its destination that has not yet visited its intermediate node is forwarded.
- R10: A header that arrives with the leg flag at 1 always leaves with `outPhase` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nodeX | input | XW | X coordinate of this node |
| nodeY | input | YW | Y coordinate of this node |
| injValid | input | 1 | Packet waiting for injection |
| injReady | output | 1 | Candidate accepted this cycle |
| stampValid | output | 1 | Stamped header fields valid |
| stampMidX | output | XW | Intermediate X written into the header |
| stampMidY | output | YW | Intermediate Y written into the header |
| stampPhase | output | 1 | Initial leg flag for the header |
| hopMidX | input | XW | Header intermediate X at this hop |
| hopMidY | input | YW | Header intermediate Y at this hop |
| hopDestX | input | XW | Header destination X at this hop |
| hopDestY | input | YW | Header destination Y at this hop |
| hopPhase | input | 1 | Header leg flag at this hop |
| outPort | output | 3 | Selected output port code |
| outPhase | output | 1 | Leg flag to forward |

## Verification
`injReady` reflects the current candidate in the same cycle as `injValid`. The stamped header appears one rising edge after acceptance. The port and leg-flag decisions follow the hop inputs combinationally, with no delay. The bench drives its inputs one nanosecond after a rising edge. It compares every output at the following falling edge against a behavioural model that steps its generator and header state only on rising edges, so each result is checked in the cycle it is due. Directed hop cases cover arrival at the intermediate node, a destination reached on the first leg, and the intermediate node equal to the source.

// File: rtl/twoLegPkg.sv
package twoLegPkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } portE;

  // strobes from draw control to the datapath
  typedef struct packed {
    logic accept;  // candidate inside the mesh, stamp it
    logic retry;   // candidate outside the mesh, draw again
  } ctlStrobeT;

endpackage

// File: rtl/twoLegDrawCtl.sv
module twoLegDrawCtl
  import twoLegPkg::*;
#(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5,
  parameter int NODES = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             injValid,
  output logic             injReady,
  output logic [IDX_W-1:0] candIdx,
  output ctlStrobeT        strobe
);

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;
  logic feedback;
  logic inRange;
  logic advance;

  assign feedback = ^(lfsr & TAPS);
  assign lfsrNext = {lfsr[LFSR_W-2:0], feedback};
  assign candIdx  = lfsr[IDX_W-1:0];

  // a power-of-two node count never needs a rejection
  generate
    if ((1 << IDX_W) == NODES) begin : g_fullRange
      assign inRange = 1'b1;
    end else begin : g_rejectRange
      assign inRange = (int'(candIdx) < NODES);
    end
  endgenerate

  assign advance       = injValid & ~rst;
  assign strobe.accept = advance & inRange;
  assign strobe.retry  = advance & ~inRange;
  assign injReady      = strobe.accept;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else if (advance) lfsr <= lfsrNext;
  end

  // R4: generator never locks up at zero
  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
  // R4: generator holds while nothing waits
  assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !injValid |=> $stable(lfsr));
  // R4: generator moves on every draw
  assert_lfsr_step_R4: assert property (@(posedge clk) disable iff (rst)
    injValid |=> lfsr != $past(lfsr));

endmodule

// File: rtl/twoLegHopSel.sv
module twoLegHopSel
  import twoLegPkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] hereX,
  input  logic [YW-1:0] hereY,
  input  logic [XW-1:0] midX,
  input  logic [YW-1:0] midY,
  input  logic [XW-1:0] destX,
  input  logic [YW-1:0] destY,
  input  logic          phaseIn,
  output portE          port,
  output logic          phaseOut
);

  logic atMid;
  logic [XW-1:0] tgtX;
  logic [YW-1:0] tgtY;

  assign atMid    = (hereX == midX) && (hereY == midY);
  assign phaseOut = phaseIn | atMid;
  assign tgtX     = phaseOut ? destX : midX;
  assign tgtY     = phaseOut ? destY : midY;

  always_comb begin
    if (tgtX > hereX)      port = PORT_EAST;
    else if (tgtX < hereX) port = PORT_WEST;
    else if (tgtY > hereY) port = PORT_NORTH;
    else if (tgtY < hereY) port = PORT_SOUTH;
    else                   port = PORT_LOCAL;
  end

  // R9: ejection only at the destination on the second leg
  assert_local_final_R9: assert property (@(posedge clk) disable iff (rst)
    port == PORT_LOCAL |-> phaseOut && hereX == destX && hereY == destY);
  // R10: leg flag is never cleared
  assert_phase_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    phaseIn |-> phaseOut);
  // R7: Y moves only once X is resolved
  assert_x_first_R7: assert property (@(posedge clk) disable iff (rst)
    (port == PORT_NORTH || port == PORT_SOUTH) |->
      hereX == (phaseOut ? destX : midX));

endmodule

// File: rtl/twoLegPath.sv
module twoLegPath
  import twoLegPkg::*;
#(
  parameter int MESH_X = 3,
  parameter int MESH_Y = 3,
  parameter int IDX_W = 4,
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobeT        strobe,
  input  logic [IDX_W-1:0] candIdx,
  input  logic [XW-1:0]    nodeX,
  input  logic [YW-1:0]    nodeY,
  output logic             stampValid,
  output logic [XW-1:0]    stampMidX,
  output logic [YW-1:0]    stampMidY,
  output logic             stampPhase,
  input  logic [XW-1:0]    hopMidX,
  input  logic [YW-1:0]    hopMidY,
  input  logic [XW-1:0]    hopDestX,
  input  logic [YW-1:0]    hopDestY,
  input  logic             hopPhase,
  output portE             outPort,
  output logic             outPhase
);

  localparam logic [IDX_W-1:0] ROW_LEN = IDX_W'(MESH_X);

  logic [XW-1:0] candX;
  logic [YW-1:0] candY;
  logic candAtSrc;

  assign candX     = XW'(candIdx % ROW_LEN);
  assign candY     = YW'(candIdx / ROW_LEN);
  assign candAtSrc = (candX == nodeX) && (candY == nodeY);

  always_ff @(posedge clk) begin
    if (rst) begin
      stampValid <= 1'b0;
      stampMidX  <= '0;
      stampMidY  <= '0;
      stampPhase <= 1'b0;
    end else begin
      stampValid <= strobe.accept;
      if (strobe.accept) begin
        stampMidX  <= candX;
        stampMidY  <= candY;
        stampPhase <= candAtSrc;
      end
    end
  end

  twoLegHopSel #(.XW(XW), .YW(YW)) i_hopSel (
    .clk     (clk),
    .rst     (rst),
    .hereX   (nodeX),
    .hereY   (nodeY),
    .midX    (hopMidX),
    .midY    (hopMidY),
    .destX   (hopDestX),
    .destY   (hopDestY),
    .phaseIn (hopPhase),
    .port    (outPort),
    .phaseOut(outPhase)
  );

  // R5: an accepted draw is stamped on the next edge
  assert_stamp_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.accept |=> stampValid);
  // R3: a rejected draw stamps nothing
  assert_no_stamp_after_retry_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.retry |=> !stampValid);
  // R2: stamped node lies inside the mesh
  assert_stamp_in_mesh_R2: assert property (@(posedge clk) disable iff (rst)
    stampValid |-> int'(stampMidX) < MESH_X && int'(stampMidY) < MESH_Y);
  // R6: initial leg flag matches the source of the accept cycle
  assert_stamp_phase_R6: assert property (@(posedge clk) disable iff (rst)
    stampValid |-> stampPhase ==
      (stampMidX == $past(nodeX) && stampMidY == $past(nodeY)));

endmodule

// File: rtl/twoLegRouteCtl.sv
module twoLegRouteCtl
  import twoLegPkg::*;
#(
  parameter int MESH_X = 3,
  parameter int MESH_Y = 3,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(MESH_X)-1:0]  nodeX,
  input  logic [$clog2(MESH_Y)-1:0]  nodeY,
  input  logic                       injValid,
  output logic                       injReady,
  output logic                       stampValid,
  output logic [$clog2(MESH_X)-1:0]  stampMidX,
  output logic [$clog2(MESH_Y)-1:0]  stampMidY,
  output logic                       stampPhase,
  input  logic [$clog2(MESH_X)-1:0]  hopMidX,
  input  logic [$clog2(MESH_Y)-1:0]  hopMidY,
  input  logic [$clog2(MESH_X)-1:0]  hopDestX,
  input  logic [$clog2(MESH_Y)-1:0]  hopDestY,
  input  logic                       hopPhase,
  output logic [2:0]                 outPort,
  output logic                       outPhase
);

  localparam int XW    = $clog2(MESH_X);
  localparam int YW    = $clog2(MESH_Y);
  localparam int NODES = MESH_X * MESH_Y;
  localparam int IDX_W = $clog2(NODES);

  ctlStrobeT strobe;
  logic [IDX_W-1:0] candIdx;
  portE portSel;

  twoLegDrawCtl #(
    .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED), .NODES(NODES), .IDX_W(IDX_W)
  ) i_drawCtl (
    .clk     (clk),
    .rst     (rst),
    .injValid(injValid),
    .injReady(injReady),
    .candIdx (candIdx),
    .strobe  (strobe)
  );

  twoLegPath #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .IDX_W(IDX_W), .XW(XW), .YW(YW)
  ) i_path (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .candIdx   (candIdx),
    .nodeX     (nodeX),
    .nodeY     (nodeY),
    .stampValid(stampValid),
    .stampMidX (stampMidX),
    .stampMidY (stampMidY),
    .stampPhase(stampPhase),
    .hopMidX   (hopMidX),
    .hopMidY   (hopMidY),
    .hopDestX  (hopDestX),
    .hopDestY  (hopDestY),
    .hopPhase  (hopPhase),
    .outPort   (portSel),
    .outPhase  (outPhase)
  );

  assign outPort = portSel;

endmodule

// File: tb/test_twoLegRouteCtl.sv
module test_twoLegRouteCtl;

  localparam int NX = 3;
  localparam int NY = 3;
  localparam int NN = NX * NY;
  localparam int SEEDV = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] nodeX = '0, nodeY = '0;
  logic injValid = 1'b0;
  logic injReady, stampValid, stampPhase, outPhase;
  logic [1:0] stampMidX, stampMidY;
  logic [1:0] hopMidX = '0, hopMidY = '0, hopDestX = '0, hopDestY = '0;
  logic hopPhase = 1'b0;
  logic [2:0] outPort;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model state
  int mLfsr = SEEDV;
  int mSv = 0, mSx = 0, mSy = 0, mSp = 0;
  bit seen [NN];
  int rejects = 0;
  int stampsSeen = 0;

  always #2.5 clk = ~clk;

  twoLegRouteCtl i_twoLegRouteCtl (
    .clk(clk), .rst(rst), .nodeX(nodeX), .nodeY(nodeY),
    .injValid(injValid), .injReady(injReady),
    .stampValid(stampValid), .stampMidX(stampMidX), .stampMidY(stampMidY),
    .stampPhase(stampPhase),
    .hopMidX(hopMidX), .hopMidY(hopMidY), .hopDestX(hopDestX), .hopDestY(hopDestY),
    .hopPhase(hopPhase), .outPort(outPort), .outPhase(outPhase)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int refPort(int hx, int hy, int mx, int my, int dx, int dy, int ph);
    int tx, ty;
    int p = ph;
    if (hx == mx && hy == my) p = 1;
    tx = p ? dx : mx;
    ty = p ? dy : my;
    if (tx > hx) return 1;
    if (tx < hx) return 2;
    if (ty > hy) return 3;
    if (ty < hy) return 4;
    return 0;
  endfunction

  function automatic int refPhase(int hx, int hy, int mx, int my, int ph);
    return (ph != 0 || (hx == mx && hy == my)) ? 1 : 0;
  endfunction

  function automatic int lfsrStep(int v);
    int fb = ((v >> 7) ^ (v >> 5) ^ (v >> 4) ^ (v >> 3)) & 1;
    return ((v << 1) & 8'hFF) | fb;
  endfunction

  // compare at the falling edge, then advance the model on the rising edge
  task automatic step();
    int cand, expReady;
    @(negedge clk);
    cand = mLfsr & 15;
    expReady = (!rst && injValid && cand < NN) ? 1 : 0;
    chk(int'(injReady), expReady, "R3 injReady");
    chk(int'(stampValid), mSv, "R5 stampValid");
    if (mSv != 0) begin
      chk(int'(stampMidX), mSx, "R2 stampMidX");
      chk(int'(stampMidY), mSy, "R2 stampMidY");
      chk(int'(stampPhase), mSp, "R6 stampPhase");
    end
    chk(int'(outPort), refPort(nodeX, nodeY, hopMidX, hopMidY, hopDestX, hopDestY, hopPhase),
        "R7 outPort");
    chk(int'(outPhase), refPhase(nodeX, nodeY, hopMidX, hopMidY, hopPhase), "R8 outPhase");
    @(posedge clk);
    if (rst) begin
      mLfsr = SEEDV;
      mSv = 0;
    end else begin
      mSv = 0;
      if (injValid) begin
        if (cand < NN) begin
          mSv = 1;
          mSx = cand % NX;
          mSy = cand / NX;
          mSp = (mSx == nodeX && mSy == nodeY) ? 1 : 0;
          seen[cand] = 1;
          stampsSeen++;
        end else rejects++;
        mLfsr = lfsrStep(mLfsr);
      end
    end
    #1;
  endtask

  task automatic setHop(int hx, int hy, int mx, int my, int dx, int dy, int ph);
    nodeX = 2'(hx); nodeY = 2'(hy);
    hopMidX = 2'(mx); hopMidY = 2'(my);
    hopDestX = 2'(dx); hopDestY = 2'(dy);
    hopPhase = ph[0];
  endtask

  initial begin
    // R1: reset holds the block idle
    repeat (3) step();
    #0;
    chk(int'(injReady), 0, "R1 ready in reset");
    chk(int'(stampValid), 0, "R1 stamp in reset");
    rst = 1'b0;
    // R1: first draw after reset uses SEED (low bits 5 -> node (2,1))
    injValid = 1'b1;
    nodeX = 2'd2; nodeY = 2'd1;
    step();
    injValid = 1'b0;
    step();
    chk(int'(stampMidX), 2, "R1 first stamp X");
    chk(int'(stampMidY), 1, "R1 first stamp Y");
    chk(int'(stampPhase), 1, "R6 mid equals source");

    // directed hop cases
    setHop(1, 1, 1, 1, 2, 0, 0); step();                // R8 arrival at intermediate
    chk(int'(outPort), 1, "R8 turn toward dest east");
    chk(int'(outPhase), 1, "R8 flag set at intermediate");
    setHop(2, 0, 0, 2, 2, 0, 0); step();                // R9 dest on first leg
    chk(int'(outPort), 2, "R9 no ejection on first leg");
    setHop(2, 0, 0, 2, 2, 0, 1); step();
    chk(int'(outPort), 0, "R9 eject on second leg");
    setHop(0, 2, 0, 0, 0, 0, 0); step();                // R7 X aligned -> south
    chk(int'(outPort), 4, "R7 south after X done");
    setHop(0, 0, 2, 2, 1, 1, 0); step();                // R7 X first
    chk(int'(outPort), 1, "R7 east before north");
    setHop(0, 1, 2, 2, 0, 2, 1); step();                // R10 sticky flag
    chk(int'(outPhase), 1, "R10 flag kept");
    chk(int'(outPort), 3, "R8 second leg toward dest");

    // random traffic with bursty injection
    for (int i = 0; i < 1500; i++) begin
      injValid = ($urandom_range(0, 3) != 0);
      setHop($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2),
             $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2),
             $urandom_range(0, 1));
      step();
    end
    injValid = 1'b0;
    // R4: idle cycles keep the generator, model predicts the next draw
    repeat (5) step();
    injValid = 1'b1;
    repeat (20) step();
    injValid = 1'b0;
    step();

    for (int k = 0; k < NN; k++) chk(int'(seen[k]), 1, "R2 every node drawn");
    chk(int'(rejects > 0), 1, "R3 rejections occurred");
    chk(int'(stampsSeen > 100), 1, "R5 stamps produced");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule